// File: doc/BRIEF.md
# Transmit Jabber Guard and Heartbeat Generator

This block watches the transmit side of a fiber Ethernet attachment unit. It measures how long each transmission lasts and, when one runs past a trip limit, locks the transmitter out. The lockout lasts until the transmit input has stayed quiet for a separate release interval. While the lockout holds, the block raises a status flag and keeps the collision oscillator running.

After each normal transmission, the block waits a short delay and then drives a heartbeat burst on the collision indication. This lets the attached station confirm that its collision path works. The heartbeat is withheld in three cases: the mode strap does not ask for it, the optical receive side reports low light, or the lockout is active.

The block also flags a collision whenever transmit and receive are active together and loopback is enabled. The heartbeat, the lockout and collision detection all share one collision oscillator. It runs from a 20 MHz clock and produces a 10 MHz square wave by toggling on every clock cycle. All intervals are parameters counted in clock cycles, so a bench can use short values.

Top module: `jabber_sqe_ctrl`

## Requirements
- R1: After reset, `tx_en` is 1 and `jab_flag`, `col_osc_en` and `col_wave` are all 0.
- R2: With jabber enabled (`sqe_mode` 2'b00 or 2'b01), the lockout trips at the clock edge that samples `tx_act` high for the JAB_TRIP_CYC-th consecutive time. `jab_flag` reads 1 after that edge. A shorter run of `tx_act` never trips it.
- R3: Once tripped, `jab_flag` stays 1 until the edge that samples `tx_act` low for the JAB_IDLE_CYC-th consecutive time. Any sample of `tx_act` high during the lockout restarts that count.
- R4: `tx_en` is 0 exactly while `jab_flag` is 1.
- R5: With `sqe_mode` 2'b01, an edge that samples `tx_act` low after a high sample starts the heartbeat. `col_osc_en` then rises SQE_DLY_CYC edges later and stays high for SQE_LEN_CYC cycles.
- R6: No heartbeat starts in any of these cases: `low_light` is 1 at the falling sample, `jab_flag` is 1 at that sample, or `sqe_mode` is not 2'b01. A pending heartbeat is dropped if `tx_act` is sampled high again before it begins.
- R7: With `sqe_mode` 2'b10 or 2'b11, the lockout is disabled and `jab_flag` stays 0 however long `tx_act` is held high. The heartbeat is also disabled in these settings.
- R8: With `lb_dis` 0, a clock edge that samples both `tx_act` and `rx_act` high makes `col_osc_en` 1 for the following cycle. With `lb_dis` 1, overlap of transmit and receive raises no collision.
- R9: While `col_osc_en` is 1, `col_wave` inverts at every clock edge. One edge after `col_osc_en` is 0, `col_wave` is 0, which is its idle level.
- R10: `col_osc_en` is 1 for as long as `jab_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| tx_act | input | 1 | Sampled flag: transmit data is present |
| rx_act | input | 1 | Sampled flag: receive data is present |
| low_light | input | 1 | Optical receiver reports low light |
| lb_dis | input | 1 | Loopback-disable strap; 1 also disables collision detection |
| sqe_mode | input | 2 | Mode strap: 00 heartbeat off, 01 heartbeat on, 10 or 11 heartbeat and lockout both off |
| tx_en | output | 1 | Transmitter enable; 0 during lockout |
| col_osc_en | output | 1 | Collision oscillator enable |
| col_wave | output | 1 | Collision square wave at half the clock rate |
| jab_flag | output | 1 | Lockout status: 1 from the trip until the release |

## Verification
On every cycle, the assertions check four things:
- the lockout only trips on a transmitting sample and only releases on a quiet one;
- the middle strap settings keep it clear;
- a heartbeat never begins while transmit is active;
- the square wave toggles while enabled, rests at 0 otherwise, and stays enabled whenever the lockout holds or a collision was latched with loopback enabled.

Some behaviours need the bench's reference model. These are the exact edge on which the trip happens, the restart of the release count by a short burst, the heartbeat delay and length, and the suppression of the heartbeat by low light, by the lockout, by the strap and by a transmission that resumes early.

// File: rtl/jsq_pkg.sv
package jsq_pkg;
  typedef enum logic {
    JS_OK,
    JS_LOCK
  } jab_st_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_ON
  } sqe_st_e;

  // strap decode: 2'b00 lockout only, 2'b01 lockout and heartbeat, 2'b1x neither
  function automatic logic strap_jab_en(input logic [1:0] m);
    return !m[1];
  endfunction

  function automatic logic strap_sqe_en(input logic [1:0] m);
    return (m == 2'b01);
  endfunction
endpackage

// File: rtl/jsq_jabber.sv
module jsq_jabber
  import jsq_pkg::*;
#(
  parameter int unsigned TRIP_CYC = 400000,
  parameter int unsigned IDLE_CYC = 10000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act,
  input  logic jab_en,
  output logic jab_flag
);
  localparam int unsigned CMAX = (TRIP_CYC > IDLE_CYC) ? TRIP_CYC : IDLE_CYC;
  localparam int CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0] TRIP_LAST = CW'(TRIP_CYC - 1);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYC - 1);

  jab_st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic upd;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!jab_en) begin
      st_d  = JS_OK;
      cnt_d = '0;
    end else begin
      case (st_q)
        JS_OK: begin
          if (!tx_act) cnt_d = '0;
          else if (cnt_q == TRIP_LAST) begin
            st_d  = JS_LOCK;
            cnt_d = '0;
          end else cnt_d = cnt_q + CW'(1);
        end
        default: begin
          if (tx_act) cnt_d = '0;
          else if (cnt_q == IDLE_LAST) begin
            st_d  = JS_OK;
            cnt_d = '0;
          end else cnt_d = cnt_q + CW'(1);
        end
      endcase
    end
  end

  assign upd = (st_d != st_q) || (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= JS_OK;
      cnt_q <= '0;
    end else if (upd) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign jab_flag = (st_q == JS_LOCK);

  // R2
  trip_on_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jab_flag) |-> $past(tx_act));
  // R3
  release_on_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jab_flag) |-> (!$past(tx_act) || !$past(jab_en)));
  // R7
  strap_off_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !jab_en |=> !jab_flag);
endmodule

// File: rtl/jsq_sqe.sv
module jsq_sqe
  import jsq_pkg::*;
#(
  parameter int unsigned DLY_CYC = 20,
  parameter int unsigned LEN_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act,
  input  logic sqe_allow,
  output logic sqe_on
);
  localparam int unsigned SMAX = (DLY_CYC > LEN_CYC) ? DLY_CYC : LEN_CYC;
  localparam int SW = $clog2(SMAX + 1);
  localparam logic [SW-1:0] DLY_LAST = SW'(DLY_CYC - 1);
  localparam logic [SW-1:0] LEN_LAST = SW'(LEN_CYC - 1);

  sqe_st_e st_q, st_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic tx_d_q;
  logic tx_fall;
  logic upd;

  assign tx_fall = tx_d_q && !tx_act;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      SQ_IDLE: begin
        if (tx_fall && sqe_allow) begin
          st_d  = SQ_WAIT;
          cnt_d = '0;
        end
      end
      SQ_WAIT: begin
        if (tx_act) begin
          st_d  = SQ_IDLE;
          cnt_d = '0;
        end else if (cnt_q == DLY_LAST) begin
          st_d  = SQ_ON;
          cnt_d = '0;
        end else cnt_d = cnt_q + SW'(1);
      end
      default: begin
        if (cnt_q == LEN_LAST) begin
          st_d  = SQ_IDLE;
          cnt_d = '0;
        end else cnt_d = cnt_q + SW'(1);
      end
    endcase
  end

  assign upd = (st_d != st_q) || (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      tx_d_q <= 1'b0;
    end else begin
      tx_d_q <= tx_act;
      if (upd) begin
        st_q  <= st_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign sqe_on = (st_q == SQ_ON);

  // R6
  beat_starts_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqe_on) |-> !$past(tx_act));
endmodule

// File: rtl/jsq_colosc.sv
module jsq_colosc (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  output logic col_wave
);
  logic ph_q, ph_d;

  assign ph_d = osc_en ? !ph_q : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign col_wave = ph_q;

  // R9
  wave_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !col_wave);
  // R9
  wave_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |=> (col_wave != $past(col_wave)));
endmodule

// File: rtl/jabber_sqe_ctrl.sv
module jabber_sqe_ctrl
  import jsq_pkg::*;
#(
  parameter int unsigned JAB_TRIP_CYC = 400000,
  parameter int unsigned JAB_IDLE_CYC = 10000000,
  parameter int unsigned SQE_DLY_CYC  = 20,
  parameter int unsigned SQE_LEN_CYC  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_act,
  input  logic       rx_act,
  input  logic       low_light,
  input  logic       lb_dis,
  input  logic [1:0] sqe_mode,
  output logic       tx_en,
  output logic       col_osc_en,
  output logic       col_wave,
  output logic       jab_flag
);
  logic rs1_q, rs2_q;
  logic rst_i_n;
  logic col_q, col_d;
  logic sqe_on;
  logic sqe_allow;
  logic jab_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  assign jab_en    = strap_jab_en(sqe_mode);
  assign sqe_allow = strap_sqe_en(sqe_mode) && !low_light && !jab_flag;
  assign col_d     = tx_act && rx_act && !lb_dis;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) col_q <= 1'b0;
    else          col_q <= col_d;
  end

  jsq_jabber #(
    .TRIP_CYC(JAB_TRIP_CYC),
    .IDLE_CYC(JAB_IDLE_CYC)
  ) u_jab (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .tx_act  (tx_act),
    .jab_en  (jab_en),
    .jab_flag(jab_flag)
  );

  jsq_sqe #(
    .DLY_CYC(SQE_DLY_CYC),
    .LEN_CYC(SQE_LEN_CYC)
  ) u_sqe (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tx_act   (tx_act),
    .sqe_allow(sqe_allow),
    .sqe_on   (sqe_on)
  );

  assign col_osc_en = col_q || sqe_on || jab_flag;
  assign tx_en      = !jab_flag;

  jsq_colosc u_osc (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .osc_en  (col_osc_en),
    .col_wave(col_wave)
  );

  // R8
  collision_needs_loopback_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    col_q |-> $past(!lb_dis && tx_act && rx_act));
  // R10
  lockout_runs_osc_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    jab_flag |-> col_osc_en);
endmodule

// File: tb/sim_jabber_sqe_ctrl.sv
`timescale 1ns/1ps
module sim_jabber_sqe_ctrl;
  localparam int TRIP = 40;
  localparam int IDLE = 60;
  localparam int DLY  = 12;
  localparam int LEN  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_act = 1'b0, rx_act = 1'b0, low_light = 1'b0, lb_dis = 1'b0;
  logic [1:0] sqe_mode = 2'b01;
  logic tx_en, col_osc_en, col_wave, jab_flag;

  always #2 clk = ~clk;

  jabber_sqe_ctrl #(
    .JAB_TRIP_CYC(TRIP), .JAB_IDLE_CYC(IDLE),
    .SQE_DLY_CYC(DLY), .SQE_LEN_CYC(LEN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
    .low_light(low_light), .lb_dis(lb_dis), .sqe_mode(sqe_mode),
    .tx_en(tx_en), .col_osc_en(col_osc_en), .col_wave(col_wave), .jab_flag(jab_flag)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit cmp_on = 0;
  bit done = 0;

  // reference model state
  bit mr1, mr2, m_jab, m_txd, m_col, m_wave;
  int m_run, m_wait, m_rem;

  task automatic model_reset();
    m_jab = 0; m_txd = 0; m_col = 0; m_wave = 0;
    m_run = 0; m_wait = 0; m_rem = 0;
  endtask

  task automatic model_step();
    bit osc_old, jab_old, lock_allowed;
    osc_old = m_col || (m_rem > 0) || m_jab;
    jab_old = m_jab;
    lock_allowed = (sqe_mode == 2'b00) || (sqe_mode == 2'b01);
    if (!lock_allowed) begin
      m_jab = 0; m_run = 0;
    end else if (!m_jab) begin
      m_run = tx_act ? m_run + 1 : 0;
      if (m_run == TRIP) begin m_jab = 1; m_run = 0; end
    end else begin
      m_run = tx_act ? 0 : m_run + 1;
      if (m_run == IDLE) begin m_jab = 0; m_run = 0; end
    end
    if (m_rem > 0) m_rem--;
    else if (m_wait > 0) begin
      if (tx_act) m_wait = 0;
      else begin
        m_wait--;
        if (m_wait == 0) m_rem = LEN;
      end
    end else if (m_txd && !tx_act && sqe_mode == 2'b01 && !low_light && !jab_old)
      m_wait = DLY;
    m_col  = tx_act && rx_act && !lb_dis;
    m_wave = osc_old ? !m_wave : 1'b0;
    m_txd  = tx_act;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mr1 = 0; mr2 = 0; model_reset();
    end else begin
      if (!mr2) model_reset();
      else model_step();
      mr2 = mr1; mr1 = 1;
    end
  end

  task automatic chk(input bit ok, input string what, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act %b exp %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(tx_en === !m_jab, "tx_en", tx_en, !m_jab);
      chk(jab_flag === m_jab, "jab_flag", jab_flag, m_jab);
      chk(col_osc_en === (m_col || (m_rem > 0) || m_jab), "col_osc_en",
          col_osc_en, (m_col || (m_rem > 0) || m_jab));
      chk(col_wave === m_wave, "col_wave", col_wave, m_wave);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int len, input int gap);
    tx_act = 1'b1; cyc(len);
    tx_act = 1'b0; cyc(gap);
  endtask

  initial begin
    cur_req = "R1";
    cyc(3);
    cmp_on = 1;
    cyc(2);
    rst_n = 1'b1;
    cyc(4);
    // R1 explicit reset-state check
    chk(tx_en === 1'b1 && jab_flag === 1'b0 && col_osc_en === 1'b0 && col_wave === 1'b0,
        "reset_state", tx_en, 1'b1);

    // R5 R9: heartbeat after a normal frame, wave toggles during it
    cur_req = "R5 R9";
    sqe_mode = 2'b01;
    frame(20, 50);
    frame(5, 45);

    // R6: low light, strap 00, strap 10 and early retransmission suppress it
    cur_req = "R6";
    low_light = 1'b1; frame(15, 45); low_light = 1'b0;
    sqe_mode = 2'b00; frame(15, 45);
    sqe_mode = 2'b10; frame(15, 45);
    sqe_mode = 2'b01;
    frame(10, 5); frame(10, 50);

    // R8 R9: collision with loopback on, none with loopback disabled
    cur_req = "R8 R9";
    sqe_mode = 2'b00;
    tx_act = 1'b1; cyc(3); rx_act = 1'b1; cyc(6); rx_act = 1'b0; cyc(3);
    tx_act = 1'b0; cyc(10);
    lb_dis = 1'b1;
    tx_act = 1'b1; rx_act = 1'b1; cyc(8); tx_act = 1'b0; rx_act = 1'b0; cyc(10);
    lb_dis = 1'b0;

    // R2 R4 R10: run one short of the trip, then a long run that trips
    cur_req = "R2 R4 R10";
    sqe_mode = 2'b01;
    frame(TRIP - 1, 40);
    tx_act = 1'b1; cyc(TRIP + 15);
    // R3 R6: release needs a full quiet run, a burst restarts it, no heartbeat at lockout fall
    cur_req = "R3 R6";
    tx_act = 1'b0; cyc(30);
    frame(3, IDLE + 30);

    // R7: middle strap settings never lock out
    cur_req = "R7";
    sqe_mode = 2'b10; frame(TRIP + 60, 10);
    sqe_mode = 2'b11; frame(TRIP + 60, 10);
    // R7 explicit: still no lockout
    chk(jab_flag === 1'b0, "jab_flag_mid", jab_flag, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog %s act running exp finished", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule